// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block decides when a small controller stops and when it resumes. Two low-power states are supported. In the halted state instruction execution is suspended and the oscillator keeps running. Any of four wake sources can release it, and each source has its own enable flag: an overflow pulse from the free-running divider, a rising edge on either of two input ports, and a tenth-second tick. In the hold state the oscillator stop control is also asserted. Only a system reset or a high level on a dedicated hold-release port can end it, and the port level counts only if the hold-release permission flag was already set when hold was entered.

After the port level releases hold, the block waits a programmable number of clocks for the oscillator to settle before it returns to run. Every return to run that a wake source or a completed settling wait causes is marked by a one-cycle wake pulse. Port inputs are asynchronous and pass through a synchronizer before they are used. The divider overflow and the tick are internal synchronous pulses.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `running`=1, `oscStop`=0, `wakeEvt`=0, and all five flags are cleared.
- R2: A `haltReq` pulse in run, with no enabled wake source active in that cycle, moves the block to halt on the next clock: `running`=0 and `oscStop`=0.
- R3: Flag bit 0 enables the divider overflow as a halt wake source. With the bit set, a `divOvf` pulse in halt returns the block to run on the next clock. With the bit clear, the pulse has no effect.
- R4: Flag bit 3 enables the tenth-second tick as a halt wake source, with the same one-clock response as R3. With the bit clear, the tick has no effect.
- R5: Flag bits 1 and 2 enable rising edges on `portAIn` and `portBIn`. Each port passes a two-stage synchronizer and an edge register, so a rise applied in halt releases halt on the third clock. A rise that happened before halt entry, with the level held high, does not release halt.
- R6: If an enabled wake source is active in the same cycle as `haltReq`, halt is not entered and the block stays in run without a wake pulse.
- R7: `wakeEvt` is high for exactly the first cycle in run after leaving halt or the start-up wait, and at no other time.
- R8: A `holdReq` pulse in run enters hold on the next clock: `oscStop`=1 and `running`=0. `holdReq` wins over a `haltReq` in the same cycle.
- R9: In hold, all halt wake sources (divider, tick, port edges) have no effect.
- R10: Hold is left through `holdLvlIn` high, after a two-stage synchronizer, only if flag bit 4 was set when hold was entered. Flag writes made during hold do not change this.
- R11: Once released, `oscStop` falls on the third clock after the level rise. The block then stays out of run for `startupLen`+1 further clocks and returns to run with a wake pulse.
- R12: Asserting reset returns the block from halt or hold to run with no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| haltReq | input | 1 | Request to enter halt |
| holdReq | input | 1 | Request to enter hold |
| flagWr | input | 1 | Write strobe for the flag register |
| flagData | input | 5 | Flags: bit0 divider, bit1 port A, bit2 port B, bit3 tick, bit4 hold-release permission |
| divOvf | input | 1 | Divider overflow pulse |
| tenthTick | input | 1 | Tenth-second pulse |
| portAIn | input | 1 | Asynchronous port A input |
| portBIn | input | 1 | Asynchronous port B input |
| holdLvlIn | input | 1 | Asynchronous hold-release level |
| startupLen | input | 8 | Start-up wait length in clocks |
| running | output | 1 | High when instructions may execute |
| oscStop | output | 1 | High to stop the oscillator |
| wakeEvt | output | 1 | One-cycle pulse on a return to run |

## Verification
The assertions check on every cycle that halt is entered only when no wake source is active, that an active source cancels entry, that halt and hold are held while no qualifying release is present, and that a wake pulse only follows halt or the start-up wait. Only the bench scenarios can show the synchronizer latency on ports, the exact length of the start-up wait, whether a permission flag written after hold entry is ignored, and that an edge from before halt entry is not counted.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_HOLD, ST_WAIT} stby_state_t;

  typedef struct packed {
    logic latchPerm;
    logic loadCnt;
    logic decCnt;
  } stby_strobe_t;

  localparam int EN_DIV  = 0;
  localparam int EN_PA   = 1;
  localparam int EN_PB   = 2;
  localparam int EN_TICK = 3;
  localparam int EN_HOLD = 4;
  localparam int FLAG_W  = 5;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  stby_strobe_t       stb,
  input  logic               flagWr,
  input  logic [FLAG_W-1:0]  flagData,
  input  logic               divOvf,
  input  logic               tenthTick,
  input  logic               portAIn,
  input  logic               portBIn,
  input  logic               holdLvlIn,
  input  logic [CNT_W-1:0]   startupLen,
  output logic               wakeAny,
  output logic               holdRel,
  output logic               cntZero
);
  localparam int NUM_SYNC = 3;

  logic [FLAG_W-1:0]   flagQ;
  logic                permQ;
  logic [CNT_W-1:0]    cntQ;
  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] synced;
  logic [1:0]          prevQ;
  logic [1:0]          edgeHit;

  assign rawIn = {holdLvlIn, portBIn, portAIn};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '0;
      else       chainQ <= {chainQ[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = chainQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= synced[1:0];
  end

  assign edgeHit = synced[1:0] & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flagQ <= '0;
    else if (flagWr) flagQ <= flagData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              permQ <= 1'b0;
    else if (stb.latchPerm) permQ <= flagQ[EN_HOLD];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.loadCnt) cntQ <= startupLen;
    else if (stb.decCnt)  cntQ <= cntQ - 1'b1;
  end

  assign wakeAny = (flagQ[EN_DIV]  & divOvf)
                 | (flagQ[EN_PA]   & edgeHit[0])
                 | (flagQ[EN_PB]   & edgeHit[1])
                 | (flagQ[EN_TICK] & tenthTick);
  assign holdRel = permQ & synced[2];
  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/stby_control.sv
module stby_control
  import stby_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         haltReq,
  input  logic         holdReq,
  input  logic         wakeAny,
  input  logic         holdRel,
  input  logic         cntZero,
  output stby_strobe_t stb,
  output logic         running,
  output logic         oscStop,
  output logic         wakeEvt
);
  stby_state_t stateQ, stateNx;
  logic        wakeQ, wakeNx;

  always_comb begin
    stateNx = stateQ;
    wakeNx  = 1'b0;
    stb     = '0;
    unique case (stateQ)
      ST_RUN: begin
        if (holdReq) begin
          stateNx       = ST_HOLD;
          stb.latchPerm = 1'b1;
        end else if (haltReq && !wakeAny) begin
          stateNx = ST_HALT;
        end
      end
      ST_HALT: begin
        if (wakeAny) begin
          stateNx = ST_RUN;
          wakeNx  = 1'b1;
        end
      end
      ST_HOLD: begin
        if (holdRel) begin
          stateNx     = ST_WAIT;
          stb.loadCnt = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cntZero) begin
          stateNx = ST_RUN;
          wakeNx  = 1'b1;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      default: stateNx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      wakeQ  <= 1'b0;
    end else begin
      stateQ <= stateNx;
      wakeQ  <= wakeNx;
    end
  end

  assign running = (stateQ == ST_RUN);
  assign oscStop = (stateQ == ST_HOLD);
  assign wakeEvt = wakeQ;

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && haltReq && !holdReq && !wakeAny) |=> (stateQ == ST_HALT));

  // R6
  halt_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && haltReq && !holdReq && wakeAny) |=> (stateQ == ST_RUN && !wakeEvt));

  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && holdReq) |=> oscStop);

  // R9
  hold_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && !holdRel) |=> (stateQ == ST_HOLD));

  // R3
  halt_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HALT && !wakeAny) |=> (stateQ == ST_HALT));

  // R7
  wake_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |-> ($past(stateQ) == ST_HALT || $past(stateQ) == ST_WAIT));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  input  logic              holdReq,
  input  logic              flagWr,
  input  logic [4:0]        flagData,
  input  logic              divOvf,
  input  logic              tenthTick,
  input  logic              portAIn,
  input  logic              portBIn,
  input  logic              holdLvlIn,
  input  logic [CNT_W-1:0]  startupLen,
  output logic              running,
  output logic              oscStop,
  output logic              wakeEvt
);
  stby_strobe_t stb;
  logic wakeAny, holdRel, cntZero;

  stby_datapath #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .flagWr(flagWr), .flagData(flagData),
    .divOvf(divOvf), .tenthTick(tenthTick), .portAIn(portAIn), .portBIn(portBIn),
    .holdLvlIn(holdLvlIn), .startupLen(startupLen),
    .wakeAny(wakeAny), .holdRel(holdRel), .cntZero(cntZero)
  );

  stby_control u_ctl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .holdReq(holdReq),
    .wakeAny(wakeAny), .holdRel(holdRel), .cntZero(cntZero),
    .stb(stb), .running(running), .oscStop(oscStop), .wakeEvt(wakeEvt)
  );
endmodule

// File: tb/sim_stby_wake_ctrl.sv
`timescale 1ns/1ps
module sim_stby_wake_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 0, holdReq = 0, flagWr = 0;
  logic [4:0] flagData = '0;
  logic divOvf = 0, tenthTick = 0, portAIn = 0, portBIn = 0, holdLvlIn = 0;
  logic [7:0] startupLen = 8'd5;
  logic running, oscStop, wakeEvt;
  int errCnt = 0;
  int chkCnt = 0;

  always #2.5 clk = ~clk;

  stby_wake_ctrl u0 (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .holdReq(holdReq),
    .flagWr(flagWr), .flagData(flagData), .divOvf(divOvf), .tenthTick(tenthTick),
    .portAIn(portAIn), .portBIn(portBIn), .holdLvlIn(holdLvlIn),
    .startupLen(startupLen), .running(running), .oscStop(oscStop), .wakeEvt(wakeEvt)
  );

  // fields: enables[3:0] (bit0 div, bit1 portA, bit2 portB, bit3 tick), div, tick, expected wake
  localparam logic [6:0] VEC [6] = '{
    {4'b0001, 1'b1, 1'b0, 1'b1},
    {4'b0000, 1'b1, 1'b0, 1'b0},
    {4'b1000, 1'b0, 1'b1, 1'b1},
    {4'b0111, 1'b0, 1'b1, 1'b0},
    {4'b1110, 1'b1, 1'b0, 1'b0},
    {4'b1111, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic wrFlags(input logic [4:0] v);
    flagWr = 1'b1; flagData = v;
    step(1);
    flagWr = 1'b0;
  endtask

  task automatic enterHalt();
    haltReq = 1'b1;
    step(1);
    haltReq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    step(1);
    // R1 during reset
    check("R1 running in reset", running, 1);
    check("R1 oscStop in reset", oscStop, 0);
    check("R1 wakeEvt in reset", wakeEvt, 0);
    rstN = 1'b1;
    step(1);
    // R1 flags cleared: divider pulse cannot wake
    enterHalt();
    divOvf = 1; step(1); divOvf = 0;
    check("R1 flags cleared after reset", running, 0);

    for (int i = 0; i < 6; i++) begin
      doReset();
      wrFlags({1'b0, VEC[i][6:3]});
      enterHalt();
      check("R2 halted", running, 0);
      check("R2 osc kept", oscStop, 0);
      divOvf = VEC[i][2]; tenthTick = VEC[i][1];
      step(1);
      divOvf = 0; tenthTick = 0;
      check("R3 R4 wake by enabled source", running, VEC[i][0]);
      check("R7 wake pulse", wakeEvt, VEC[i][0]);
      step(1);
      check("R7 pulse one cycle", wakeEvt, 0);
    end

    // R5 port A rise in halt: release on third clock
    doReset();
    wrFlags(5'b00010);
    enterHalt();
    portAIn = 1;
    step(2);
    check("R5 port A not yet", running, 0);
    step(1);
    check("R5 port A wake", running, 1);
    check("R7 port wake pulse", wakeEvt, 1);
    portAIn = 0;
    // R5 rise before entry with level held does not count
    doReset();
    wrFlags(5'b00100);
    portBIn = 1;
    step(4);
    enterHalt();
    step(4);
    check("R5 stale port B level ignored", running, 0);
    portBIn = 0; step(3);
    portBIn = 1; step(3);
    check("R5 port B fresh rise wakes", running, 1);
    portBIn = 0;

    // R6 wake source in the entry cycle cancels halt
    doReset();
    wrFlags(5'b00001);
    haltReq = 1; divOvf = 1;
    step(1);
    haltReq = 0; divOvf = 0;
    check("R6 entry cancelled", running, 1);
    check("R6 no pulse", wakeEvt, 0);
    step(1);
    check("R6 still running", running, 1);

    // R8 hold priority over halt; R9 halt sources ignored in hold
    doReset();
    wrFlags(5'b11111);
    haltReq = 1; holdReq = 1;
    step(1);
    haltReq = 0; holdReq = 0;
    check("R8 oscStop in hold", oscStop, 1);
    check("R8 not running", running, 0);
    divOvf = 1; tenthTick = 1; portAIn = 1;
    step(1);
    divOvf = 0; tenthTick = 0;
    step(4);
    check("R9 hold ignores halt sources", oscStop, 1);
    portAIn = 0;

    // R10 R11 release with permission and start-up wait (startupLen=5)
    holdLvlIn = 1;
    step(2);
    check("R10 level not yet seen", oscStop, 1);
    step(1);
    check("R11 osc restarted", oscStop, 0);
    check("R11 waiting", running, 0);
    step(5);
    check("R11 still waiting", running, 0);
    step(1);
    check("R11 run after wait", running, 1);
    check("R7 wake after wait", wakeEvt, 1);
    holdLvlIn = 0;

    // R10 permission written during hold is ignored
    doReset();
    wrFlags(5'b00000);
    holdReq = 1; step(1); holdReq = 0;
    wrFlags(5'b10000);
    holdLvlIn = 1;
    step(8);
    check("R10 late permission ignored", oscStop, 1);
    // R12 reset releases hold
    rstN = 0; step(1);
    check("R12 reset leaves hold", oscStop, 0);
    check("R12 reset running", running, 1);
    rstN = 1; step(1);
    check("R12 no pulse on reset", wakeEvt, 0);
    holdLvlIn = 0;

    // R12 reset releases halt
    enterHalt();
    check("R12 halted before reset", running, 0);
    rstN = 0; step(1);
    check("R12 reset leaves halt", running, 1);
    rstN = 1; step(1);
    check("R12 no pulse after halt reset", wakeEvt, 0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule